// File: doc/BRIEF.md
# Universal Shift Register With Clocked Clear

A small clocked storage register, four stages wide by default, whose next contents are chosen by a two-bit mode code. Per clock edge it can capture a parallel word, move every stage one place toward the high end with a fresh bit entering the low end, move every stage one place toward the low end with a fresh bit entering the high end, or empty itself to zero. All changes happen on the rising clock edge. The block has no reset pin. Its contents are unknown after power-up until the first clear or load cycle.

The stored word leaves on two paths. The shared-bus path is released to high impedance whenever the output-drive input is low. A second copy is always driven, so neighbouring logic can read the word at any time. Releasing the bus never disturbs the stored word, and shifting goes on while the bus is released. The two end stages on the always-driven copy act as the serial outputs for chaining. The block carries no data stream with flow control, so all of its pins are plain level signals with no valid/ready handshake and no back-pressure.

Top module: `univ_shreg`

## Requirements
- R1: When the mode code {msel_hi, msel_lo} is 2'b11, the rising clock edge copies par_in[i] into stage i for every i.
- R2: During a 2'b11 cycle, neither right_ser_in nor left_ser_in has any effect on the stored word.
- R3: Mode code 2'b01 moves every stage up by one on the rising edge. Stage i+1 takes the old stage i, and stage 0 takes right_ser_in.
- R4: Mode code 2'b10 moves every stage down by one on the rising edge. Stage i takes the old stage i+1, and the top stage takes left_ser_in.
- R5: Mode code 2'b00 sets every stage to 0 on the rising edge, whatever par_in and the serial inputs hold.
- R6: While drive_en is 0, every bit of bus_q is high impedance, so another driver on the net decides its value.
- R7: While drive_en is 1, bus_q equals the stored word.
- R8: drive_en has no effect on the stored word. Loads, shifts and clears carry on while the bus is released.
- R9: word_q always shows the stored word, whatever drive_en is. word_q[0] and word_q[WIDTH-1] are the end stages for chaining.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| msel_lo | input | 1 | Low bit of the mode code |
| msel_hi | input | 1 | High bit of the mode code |
| par_in | input | WIDTH | Parallel word, captured in mode 2'b11 |
| right_ser_in | input | 1 | Serial bit entering stage 0 in mode 2'b01 |
| left_ser_in | input | 1 | Serial bit entering the top stage in mode 2'b10 |
| drive_en | input | 1 | 1 drives bus_q; 0 releases it to high impedance |
| bus_q | output | WIDTH | Stored word on the shared bus, high impedance when released |
| word_q | output | WIDTH | Stored word, always driven |

## Verification
A wrong stage shows on word_q one edge after the cycle that created it. Because every mode rewrites the whole word, a bad bit in a shift spreads one stage per edge until it falls off the end. A wrong gate shows on bus_q in the same cycle: either the bench's own driver on the net is overridden while drive_en is 0, or the value does not match word_q while drive_en is 1. The bench compares against its own model after every edge, so a fault is reported on the first edge where it shows.

// File: rtl/univ_shreg_pkg.sv
package univ_shreg_pkg;
  // Mode code is {msel_hi, msel_lo}
  typedef enum logic [1:0] {
    MODE_CLEAR = 2'b00,
    MODE_UP    = 2'b01,
    MODE_DOWN  = 2'b10,
    MODE_LOAD  = 2'b11
  } mode_e;
endpackage

// File: rtl/univ_shreg_mode_dec.sv
module univ_shreg_mode_dec
  import univ_shreg_pkg::*;
(
  input  logic  msel_lo,
  input  logic  msel_hi,
  output mode_e mode
);
  always_comb begin
    unique case ({msel_hi, msel_lo})
      2'b11:   mode = MODE_LOAD;
      2'b01:   mode = MODE_UP;
      2'b10:   mode = MODE_DOWN;
      default: mode = MODE_CLEAR;
    endcase
  end
endmodule

// File: rtl/univ_shreg_stage.sv
module univ_shreg_stage
  import univ_shreg_pkg::*;
(
  input  logic  clk,
  input  mode_e mode,
  input  logic  par_bit,
  input  logic  from_lower,
  input  logic  from_upper,
  output logic  q
);
  logic nxt;

  always_comb begin
    unique case (mode)
      MODE_LOAD:  nxt = par_bit;
      MODE_UP:    nxt = from_lower;
      MODE_DOWN:  nxt = from_upper;
      default:    nxt = 1'b0;
    endcase
  end

  always_ff @(posedge clk) q <= nxt;
endmodule

// File: rtl/univ_shreg_out_gate.sv
module univ_shreg_out_gate #(
  parameter int WIDTH = 4
) (
  input  logic             drive_en,
  input  logic [WIDTH-1:0] word,
  output wire  [WIDTH-1:0] bus
);
  assign bus = drive_en ? word : {WIDTH{1'bz}};
endmodule

// File: rtl/univ_shreg.sv
module univ_shreg
  import univ_shreg_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             msel_lo,
  input  logic             msel_hi,
  input  logic [WIDTH-1:0] par_in,
  input  logic             right_ser_in,
  input  logic             left_ser_in,
  input  logic             drive_en,
  output wire  [WIDTH-1:0] bus_q,
  output logic [WIDTH-1:0] word_q
);
  localparam int TOP = WIDTH - 1;

  mode_e            mode;
  logic [WIDTH-1:0] stage_q;

  univ_shreg_mode_dec u_dec (
    .msel_lo (msel_lo),
    .msel_hi (msel_hi),
    .mode    (mode)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic lower_src;
    logic upper_src;
    if (i == 0) begin : g_low_end
      assign lower_src = right_ser_in;
    end else begin : g_low_mid
      assign lower_src = stage_q[i-1];
    end
    if (i == TOP) begin : g_high_end
      assign upper_src = left_ser_in;
    end else begin : g_high_mid
      assign upper_src = stage_q[i+1];
    end
    univ_shreg_stage u_stage (
      .clk        (clk),
      .mode       (mode),
      .par_bit    (par_in[i]),
      .from_lower (lower_src),
      .from_upper (upper_src),
      .q          (stage_q[i])
    );
  end

  assign word_q = stage_q;

  univ_shreg_out_gate #(.WIDTH(WIDTH)) u_gate (
    .drive_en (drive_en),
    .word     (stage_q),
    .bus      (bus_q)
  );

  // Checks are enabled after two edges, once the bench's opening clear has settled the word
  logic [1:0] chk_age = 2'd0;
  always_ff @(posedge clk) if (chk_age != 2'd2) chk_age <= chk_age + 2'd1;
  logic chk_on;
  assign chk_on = (chk_age == 2'd2);

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!chk_on)
    ({msel_hi, msel_lo} == 2'b11) |=> (word_q == $past(par_in))) else $error("load"); // R1 R2
  AST_SHIFT_UP: assert property (@(posedge clk) disable iff (!chk_on)
    ({msel_hi, msel_lo} == 2'b01) |=> (word_q == {$past(word_q[WIDTH-2:0]), $past(right_ser_in)}))
    else $error("up"); // R3
  AST_SHIFT_DOWN: assert property (@(posedge clk) disable iff (!chk_on)
    ({msel_hi, msel_lo} == 2'b10) |=> (word_q == {$past(left_ser_in), $past(word_q[TOP:1])}))
    else $error("down"); // R4
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!chk_on)
    ({msel_hi, msel_lo} == 2'b00) |=> (word_q == '0)) else $error("clear"); // R5
  AST_BUS_MATCH: assert property (@(posedge clk) disable iff (!chk_on)
    drive_en |-> (bus_q == word_q)) else $error("bus"); // R7
endmodule

// File: tb/univ_shreg_bench.sv
module univ_shreg_bench;
  localparam int W = 4;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic msel_lo = 1'b0, msel_hi = 1'b0;
  logic [W-1:0] par_in = '0;
  logic right_ser_in = 1'b0, left_ser_in = 1'b0;
  logic drive_en = 1'b1;
  logic tb_drv = 1'b0;
  logic [W-1:0] tb_val = '0;
  wire  [W-1:0] bus_q;
  logic [W-1:0] word_q;
  logic [W-1:0] exp_word = '0;
  int n_run = 0, n_fail = 0;

  assign bus_q = tb_drv ? tb_val : {W{1'bz}};

  always #(CLK_PERIOD/2) clk = ~clk;

  univ_shreg #(.WIDTH(W)) u_univ_shreg (
    .clk(clk), .msel_lo(msel_lo), .msel_hi(msel_hi), .par_in(par_in),
    .right_ser_in(right_ser_in), .left_ser_in(left_ser_in),
    .drive_en(drive_en), .bus_q(bus_q), .word_q(word_q)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // One clock: drive at negedge, let the edge happen, update the model, sample 1 time unit later
  task automatic step(input logic [1:0] m, input logic [W-1:0] d, input logic sr, input logic sl);
    @(negedge clk);
    {msel_hi, msel_lo} = m;
    par_in = d; right_ser_in = sr; left_ser_in = sl;
    @(posedge clk);
    case (m)
      2'b11: exp_word = d;
      2'b01: exp_word = {exp_word[W-2:0], sr};
      2'b10: exp_word = {sl, exp_word[W-1:1]};
      default: exp_word = '0;
    endcase
    #1;
  endtask

  task automatic t_opening_clear();
    step(2'b00, 4'b1111, 1'b1, 1'b1);
    chk("R5 opening clear word", word_q, 4'b0000);
    chk("R9 word_q matches model", word_q, exp_word);
    chk("R7 bus driven", bus_q, 4'b0000);
  endtask

  task automatic t_loads();
    step(2'b11, 4'b1010, 1'b0, 1'b0); chk("R1 load 1010", word_q, 4'b1010);
    step(2'b11, 4'b0101, 1'b0, 1'b0); chk("R1 load 0101", word_q, 4'b0101);
    step(2'b11, 4'b1111, 1'b0, 1'b0); chk("R1 load 1111", word_q, 4'b1111);
    chk("R7 bus after load", bus_q, 4'b1111);
  endtask

  task automatic t_load_ignores_serial();
    step(2'b11, 4'b0110, 1'b1, 1'b1); chk("R2 serial high ignored", word_q, 4'b0110);
    step(2'b11, 4'b1001, 1'b0, 1'b1); chk("R2 serial mixed ignored", word_q, 4'b1001);
  endtask

  task automatic t_shift_up();
    step(2'b11, 4'b0000, 1'b0, 1'b0);
    step(2'b01, 4'b1111, 1'b1, 1'b0); chk("R3 up 1", word_q, 4'b0001);
    step(2'b01, 4'b1111, 1'b0, 1'b1); chk("R3 up 2", word_q, 4'b0010);
    step(2'b01, 4'b0000, 1'b1, 1'b0); chk("R3 up 3", word_q, 4'b0101);
    step(2'b01, 4'b0000, 1'b1, 1'b0); chk("R3 up 4", word_q, 4'b1011);
    chk("R9 top end stage carries first bit", {3'b000, word_q[W-1]}, 4'b0001);
  endtask

  task automatic t_shift_down();
    step(2'b11, 4'b0000, 1'b0, 1'b0);
    step(2'b10, 4'b1111, 1'b0, 1'b1); chk("R4 down 1", word_q, 4'b1000);
    step(2'b10, 4'b1111, 1'b1, 1'b0); chk("R4 down 2", word_q, 4'b0100);
    step(2'b10, 4'b0000, 1'b0, 1'b1); chk("R4 down 3", word_q, 4'b1010);
    step(2'b10, 4'b0000, 1'b0, 1'b1); chk("R4 down 4", word_q, 4'b1101);
    chk("R9 low end stage carries first bit", {3'b000, word_q[0]}, 4'b0001);
  endtask

  task automatic t_clear();
    step(2'b11, 4'b1011, 1'b0, 1'b0);
    step(2'b00, 4'b1111, 1'b1, 1'b1); chk("R5 clear over inputs", word_q, 4'b0000);
  endtask

  task automatic t_released_bus();
    step(2'b11, 4'b0110, 1'b0, 1'b0);
    @(negedge clk); drive_en = 1'b0; tb_drv = 1'b1; tb_val = 4'b1010;
    #1; chk("R6 bus released to other driver", bus_q, 4'b1010);
    tb_val = 4'b0101;
    #1; chk("R6 bus follows other driver", bus_q, 4'b0101);
    chk("R8 word kept while released", word_q, 4'b0110);
    step(2'b01, 4'b0000, 1'b1, 1'b0); chk("R8 shift while released", word_q, exp_word);
    step(2'b10, 4'b0000, 1'b0, 1'b0); chk("R8 second shift while released", word_q, exp_word);
    chk("R6 bus still released", bus_q, 4'b0101);
    @(negedge clk); tb_drv = 1'b0; drive_en = 1'b1;
    #1; chk("R7 bus driven again", bus_q, exp_word);
    chk("R9 word_q matches bus", word_q, exp_word);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_opening_clear();
    t_loads();
    t_load_ignores_serial();
    t_shift_up();
    t_shift_down();
    t_clear();
    t_released_bus();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule